// File: doc/BRIEF.md
# Set-Way Data Cache Flush Engine

This block is a hardware sequencer that empties a data cache before the power to it is removed. A single start pulse makes it visit every line of a 32 KB, 4-way set-associative cache with 32-byte lines. It addresses each line by index, meaning the way number and the set number, and never by a memory address. For each line it reads the line's state and acts on it:

- a modified line is first written to memory over a request/acknowledge port, and then its valid state is cleared;
- an unmodified valid line is only invalidated;
- an empty line is passed over with no memory traffic and no invalidate.

The cache arrays stay outside the block. The engine drives an index address with a read strobe. The tag/state array and the line data array both answer one cycle later. The same index address is used to point the invalidate strobe at the line. A one-cycle done pulse marks the end of the walk, and the power controller can then gate the cache.

Top module: `dcache_flush_engine`

## Requirements
- R1: The index address `idx_o` equals way × 8192 + set × 32. The way number sits at bit 13 and above, the set number in bits 12..5, and bits 4..0 are always zero.
- R2: The walk visits way 0 first and goes on in ascending way order. Within each way it visits sets 0 to 255 in ascending order, which makes 1024 line visits.
- R3: `rd_o` is high for exactly one cycle per visited line. The tag, valid, dirty and data inputs are taken in the cycle that follows it.
- R4: A line whose valid input is 0 causes no writeback request and no invalidate, and costs exactly two cycles. A walk over an empty cache therefore raises `done_o` 2049 cycles after the cycle in which start was sampled.
- R5: A valid line that is not dirty gets a one-cycle `inv_o` with its index on `idx_o` and no writeback, and costs three cycles. A walk over a fully clean cache raises `done_o` 3073 cycles after the start cycle.
- R6: A valid dirty line raises `wb_req_o`. `wb_addr_o` is tag × 8192 + set × 32, and `wb_data_o` is the line data read for it. Request, address and data stay unchanged until `wb_ack_i` is seen high.
- R7: The invalidate of a dirty line comes in the cycle right after the cycle in which its writeback acknowledge was accepted, and never before it.
- R8: `done_o` is a one-cycle pulse that comes after the last line has been handled. `busy_o` is high from the cycle after start up to and including the done cycle, and low in the cycle after that.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The walk continues in order and produces a single done pulse.
- R10: During and right after reset, `busy_o`, `done_o`, `rd_o`, `inv_o` and `wb_req_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a walk when the engine is idle |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse at the end of the walk |
| idx_o | output | 15 | Index address (way, set) for reads and invalidate |
| rd_o | output | 1 | Read strobe for the tag/state and data arrays |
| tag_valid_i | input | 1 | Valid state of the line read, one cycle after `rd_o` |
| tag_dirty_i | input | 1 | Dirty state of the line read |
| tag_i | input | 19 | Tag of the line read |
| data_i | input | 256 | Data of the line read |
| inv_o | output | 1 | Invalidate strobe for the line at `idx_o` |
| wb_req_o | output | 1 | Writeback request, held until acknowledged |
| wb_addr_o | output | 32 | Memory address of the line being written back |
| wb_data_o | output | 256 | Line data being written back |
| wb_ack_i | input | 1 | Writeback acknowledge |

## Verification
The bench runs four full walks, each over a cache image that is computed arithmetically:

- **All empty.** This walk pins the two-cycle skip cost and shows that an empty line causes no traffic.
- **All clean.** This walk pins the three-cycle invalidate cost and shows that no writeback appears for clean lines.
- **All dirty.** Every line must write back with the right address and data before it is invalidated. The acknowledge comes after a delay that varies from line to line, so the hold of the request and the order of writeback and invalidate are both tested.
- **Mixed.** Empty, clean and dirty lines are interleaved, so the visit order must skip the correct lines. A second start pulse arrives in the middle of this walk, and a restart would break the expected index sequence.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_EVAL,
        ST_WB,
        ST_INV,
        ST_DONE
    } dcf_state_e;

    typedef struct packed {
        logic valid;
        logic dirty;
    } dcf_line_st_t;

    typedef enum logic [1:0] {
        ACT_SKIP,
        ACT_DROP,
        ACT_FLUSH
    } dcf_act_e;

    function automatic dcf_act_e dcf_classify(dcf_line_st_t st);
        if (!st.valid) begin
            return ACT_SKIP;
        end
        if (st.dirty) begin
            return ACT_FLUSH;
        end
        return ACT_DROP;
    endfunction

endpackage

// File: rtl/dcf_walk_ctr.sv
module dcf_walk_ctr #(
    parameter int WAY_W = 2,
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [WAY_W-1:0] way_o,
    output logic [SET_W-1:0] set_o,
    output logic             last_o
);
    localparam int LINE_W = WAY_W + SET_W;

    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            line_q <= '0;
        end else if (step_i) begin
            line_q <= line_q + 1'b1;
        end
    end

    assign {way_o, set_o} = line_q;
    assign last_o         = &line_q;

    // R2
    walk_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && last_o && !clear_i) |=> (line_q == '0));

endmodule

// File: rtl/dcf_wb_stage.sv
module dcf_wb_stage #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 19,
    parameter int SET_W  = 8,
    parameter int OFS_W  = 5,
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic [SET_W-1:0]  set_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_o  <= 1'b0;
            addr_o <= '0;
            data_o <= '0;
        end else if (load_i) begin
            req_o  <= 1'b1;
            addr_o <= {tag_i, set_i, {OFS_W{1'b0}}};
            data_o <= data_i;
        end else if (ack_i) begin
            req_o  <= 1'b0;
        end
    end

    // R6
    wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_o && !ack_i && !load_i) |=> (req_o && $stable(addr_o) && $stable(data_o)));

endmodule

// File: rtl/dcache_flush_engine.sv
module dcache_flush_engine #(
    parameter int ADDR_W      = 32,
    parameter int CACHE_BYTES = 32768,
    parameter int WAYS        = 4,
    parameter int LINE_BYTES  = 32
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          start_i,
    output logic                                          busy_o,
    output logic                                          done_o,
    output logic [$clog2(CACHE_BYTES)-1:0]                idx_o,
    output logic                                          rd_o,
    input  logic                                          tag_valid_i,
    input  logic                                          tag_dirty_i,
    input  logic [ADDR_W-$clog2(CACHE_BYTES/WAYS)-1:0]    tag_i,
    input  logic [LINE_BYTES*8-1:0]                       data_i,
    output logic                                          inv_o,
    output logic                                          wb_req_o,
    output logic [ADDR_W-1:0]                             wb_addr_o,
    output logic [LINE_BYTES*8-1:0]                       wb_data_o,
    input  logic                                          wb_ack_i
);
    import dcf_pkg::*;

    localparam int WAY_BYTES = CACHE_BYTES / WAYS;
    localparam int OFS_W     = $clog2(LINE_BYTES);
    localparam int WAY_SHIFT = $clog2(WAY_BYTES);
    localparam int SET_W     = WAY_SHIFT - OFS_W;
    localparam int WAY_W     = $clog2(WAYS);
    localparam int IDX_W     = $clog2(CACHE_BYTES);
    localparam int TAG_W     = ADDR_W - WAY_SHIFT;
    localparam int DATA_W    = LINE_BYTES * 8;

    dcf_state_e       state_q, state_d;
    dcf_act_e         act;
    dcf_line_st_t     line_st;
    logic [WAY_W-1:0] way;
    logic [SET_W-1:0] set;
    logic             last, step, clear, load;

    assign line_st = '{valid: tag_valid_i, dirty: tag_dirty_i};
    assign act     = dcf_classify(line_st);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_LOOK;
            ST_LOOK: state_d = ST_EVAL;
            ST_EVAL: begin
                unique case (act)
                    ACT_FLUSH: state_d = ST_WB;
                    ACT_DROP:  state_d = ST_INV;
                    default:   state_d = last ? ST_DONE : ST_LOOK;
                endcase
            end
            ST_WB:   if (wb_ack_i) state_d = ST_INV;
            ST_INV:  state_d = last ? ST_DONE : ST_LOOK;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign clear = (state_q == ST_IDLE) && start_i;
    assign step  = (state_q == ST_INV) || ((state_q == ST_EVAL) && (act == ACT_SKIP));
    assign load  = (state_q == ST_EVAL) && (act == ACT_FLUSH);

    dcf_walk_ctr #(
        .WAY_W(WAY_W),
        .SET_W(SET_W)
    ) u_walk (
        .clk    (clk),
        .rst    (rst),
        .clear_i(clear),
        .step_i (step),
        .way_o  (way),
        .set_o  (set),
        .last_o (last)
    );

    dcf_wb_stage #(
        .ADDR_W(ADDR_W),
        .TAG_W (TAG_W),
        .SET_W (SET_W),
        .OFS_W (OFS_W),
        .DATA_W(DATA_W)
    ) u_wb (
        .clk   (clk),
        .rst   (rst),
        .load_i(load),
        .tag_i (tag_i),
        .set_i (set),
        .data_i(data_i),
        .ack_i (wb_ack_i),
        .req_o (wb_req_o),
        .addr_o(wb_addr_o),
        .data_o(wb_data_o)
    );

    assign idx_o  = (IDX_W'(way) << WAY_SHIFT) | (IDX_W'(set) << OFS_W);
    assign rd_o   = (state_q == ST_LOOK);
    assign inv_o  = (state_q == ST_INV);
    assign done_o = (state_q == ST_DONE);
    assign busy_o = (state_q != ST_IDLE);

    // R7
    inv_order_chk: assert property (@(posedge clk) disable iff (rst)
        inv_o |-> ($past(wb_ack_i) || $past(tag_valid_i && !tag_dirty_i)));

    // R4
    skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_EVAL) && !tag_valid_i) |=> (!wb_req_o && !inv_o));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

    // R3
    one_action_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_o, inv_o, wb_req_o, done_o}));

endmodule

// File: tb/dcache_flush_engine_tb.sv
module dcache_flush_engine_tb;

    localparam int LINES = 1024;
    localparam int SETS  = 256;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         busy_o, done_o, rd_o, inv_o, wb_req_o;
    logic [14:0]  idx_o;
    logic         tag_valid_i = 1'b0;
    logic         tag_dirty_i = 1'b0;
    logic [18:0]  tag_i = '0;
    logic [255:0] data_i = '0;
    logic [31:0]  wb_addr_o;
    logic [255:0] wb_data_o;
    logic         wb_ack_i = 1'b0;

    always #4 clk = ~clk;

    dcache_flush_engine u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
        .idx_o(idx_o), .rd_o(rd_o), .tag_valid_i(tag_valid_i), .tag_dirty_i(tag_dirty_i),
        .tag_i(tag_i), .data_i(data_i), .inv_o(inv_o), .wb_req_o(wb_req_o),
        .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o), .wb_ack_i(wb_ack_i)
    );

    int checks = 0;
    int failures = 0;
    int mode = 0;
    bit en = 1'b0;
    int exp_line, issued_line, acked_line, wb_cnt, inv_cnt, done_cnt;
    bit prev_req = 1'b0;
    bit prev_ack = 1'b0;

    function automatic bit lv(int l);
        case (mode)
            0:       return 1'b0;
            1, 2:    return 1'b1;
            default: return (l % 3) != 0;
        endcase
    endfunction

    function automatic bit ld(int l);
        case (mode)
            0, 1:    return 1'b0;
            2:       return 1'b1;
            default: return ((l % 5) == 0) || ((l % 7) == 3);
        endcase
    endfunction

    function automatic logic [18:0] lt(int l);
        return 19'(l * 37 + 11);
    endfunction

    function automatic logic [255:0] ldat(int l);
        logic [31:0] w;
        w = (32'(l) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
        return {8{w}};
    endfunction

    function automatic int nv(int from);
        int f = from;
        while (f < LINES && !lv(f)) f++;
        return f;
    endfunction

    function automatic longint exp_idx(int l);
        return longint'((l / SETS) * 8192 + (l % SETS) * 32);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // cache array model: one-cycle read latency
    initial begin
        forever begin
            bit r;
            int a;
            @(negedge clk);
            r = rd_o;
            a = int'(idx_o) >> 5;
            @(posedge clk);
            #1;
            if (r) begin
                tag_valid_i = lv(a);
                tag_dirty_i = ld(a);
                tag_i       = lt(a);
                data_i      = ldat(a);
            end
        end
    end

    // writeback acknowledge model with a per-line delay
    initial begin
        int wcnt = 0;
        forever begin
            @(negedge clk);
            if (wb_req_o) begin
                if (wcnt == int'(wb_addr_o[6:5])) begin
                    @(posedge clk);
                    #1 wb_ack_i = 1'b1;
                    acked_line = issued_line;
                    @(posedge clk);
                    #1 wb_ack_i = 1'b0;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // event monitor
    initial begin
        forever begin
            @(negedge clk);
            if (en) begin
                if (wb_req_o && !prev_req) begin
                    check(exp_line < LINES && lv(exp_line) && ld(exp_line), "R6", "writeback on non-dirty line",
                          exp_line, exp_line);
                    check(longint'(wb_addr_o) == longint'(lt(exp_line)) * 8192 + (exp_line % SETS) * 32,
                          "R6", "writeback address", wb_addr_o,
                          longint'(lt(exp_line)) * 8192 + (exp_line % SETS) * 32);
                    check(wb_data_o == ldat(exp_line), "R6", "writeback data",
                          longint'(wb_data_o[63:0]), longint'(ldat(exp_line)[63:0]));
                    issued_line = exp_line;
                    wb_cnt++;
                end
                if (inv_o) begin
                    check(idx_o[4:0] == 5'd0, "R1", "index offset bits", idx_o[4:0], 0);
                    check(longint'(idx_o) == exp_idx(exp_line), "R2", "invalidate index order",
                          idx_o, exp_idx(exp_line));
                    if (ld(exp_line)) begin
                        check(prev_ack && acked_line == exp_line, "R7", "invalidate before ack",
                              acked_line, exp_line);
                    end else begin
                        check(issued_line != exp_line, "R5", "clean line written back",
                              issued_line, -1);
                    end
                    inv_cnt++;
                    exp_line = nv(exp_line + 1);
                end
                if (done_o) begin
                    check(exp_line == LINES, "R8", "done before all lines", exp_line, LINES);
                    done_cnt++;
                end
            end
            prev_req = wb_req_o;
            prev_ack = wb_ack_i;
        end
    end

    task automatic run(input int m, input int exp_cycles, input bit inject, input string tag);
        int n = 0;
        int nd = 0;
        int nvld = 0;
        mode = m;
        for (int l = 0; l < LINES; l++) begin
            if (lv(l)) nvld++;
            if (lv(l) && ld(l)) nd++;
        end
        exp_line = nv(0);
        issued_line = -1;
        acked_line = -1;
        wb_cnt = 0;
        inv_cnt = 0;
        done_cnt = 0;
        en = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        forever begin
            @(negedge clk);
            if (done_o) break;
            n++;
            if (n == 1) check(busy_o, "R8", "busy after start", busy_o, 1);
            if (inject && n == 400) start_i = 1'b1;
            if (inject && n == 401) start_i = 1'b0;
        end
        @(negedge clk);
        check(!done_o, "R8", "done longer than one cycle", done_o, 0);
        check(!busy_o, "R8", "busy after done", busy_o, 0);
        en = 1'b0;
        if (exp_cycles >= 0) check(n == exp_cycles, tag, "walk length", n, exp_cycles);
        check(wb_cnt == nd, "R6", "writeback count", wb_cnt, nd);
        check(inv_cnt == nvld, "R5", "invalidate count", inv_cnt, nvld);
        if (inject) check(done_cnt == 1, "R9", "done count with late start", done_cnt, 1);
        else        check(done_cnt == 1, "R8", "done count", done_cnt, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({busy_o, done_o, rd_o, inv_o, wb_req_o} == 5'b0, "R10", "outputs in reset",
              {busy_o, done_o, rd_o, inv_o, wb_req_o}, 0);
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check({busy_o, done_o, rd_o, inv_o, wb_req_o} == 5'b0, "R10", "outputs after reset",
              {busy_o, done_o, rd_o, inv_o, wb_req_o}, 0);
        run(0, 2048, 1'b0, "R4");   // R4: empty cache, two cycles per line, no traffic
        run(1, 3072, 1'b0, "R5");   // R5: clean cache, three cycles per line
        run(2, -1, 1'b0, "R6");     // R6 R7: every line dirty, varying ack delay
        run(3, -1, 1'b1, "R9");     // R9 R3: mixed image, start pulse while busy
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule